// File: doc/BRIEF.md
# DMA Channel Scheduler with Overrun Halt

This block chooses which of seven DMA channels may run a transfer next and hands that channel a one-hot grant. A channel is eligible when its enable bit in the priority/enable control word is set and its request is active. The grant is held until the transfer engine reports either normal completion or an overrun. An overrun means the transfer used up its cycle budget. Channels are visited in ascending index order. A pass that reaches the top index starts again from channel 0.

An overrun freezes all scheduling for a fixed halt period. While the halt runs, control writes and request changes only update state; they start nothing. When the halt expires, the scan starts again from channel 0. A further overrun during that scan cuts the scan short and starts a new halt.

The highest-index channel is the table-clear channel. It has no request pin. Its request is a latch that is loaded from a start bit when its control register is written, and it is cleared when its transfer completes. Every finished or overrun transfer reports its cycle usage for one cycle, so the CPU can be stalled for that many cycles.

Top module: `dma_sched`

## Requirements
- R1: After reset, `ctrl_q_o` reads 0x07654321, `grant_o` is 0, `halted_o` is 0 and `stall_vld_o` is 0.
- R2: Channel i may be granted only when bit 4*i+3 of `ctrl_q_o` is 1 and its request is active. The request is `req_i[i]` for i below 6 and the table-clear latch for i = 6. When channels are eligible from an idle start, the lowest-indexed one is granted.
- R3: `grant_o` has at most one bit set. It stays unchanged until `done_i` or `ovr_i` is seen, and it is 0 in the cycle after either of them.
- R4: Within one pass, grants are issued in strictly ascending channel index. After the highest eligible index is served, the next pass begins again at channel 0.
- R5: An `ovr_i` pulse during a grant drops the grant, and `halted_o` is then high for exactly HALT_CYC (100) consecutive cycles.
- R6: While `halted_o` is high, no channel is granted. This holds for control writes, table-clear writes and request changes alike.
- R7: When the halt ends, the scan restarts at channel 0 and grants the lowest eligible channel first.
- R8: An overrun during the resumed scan abandons the rest of that scan and starts another full halt of HALT_CYC cycles.
- R9: A write on `clr_wr_i` sets the table-clear request to `clr_start_i`. So a 0 withdraws a pending request. Completion (`done_i`) of a table-clear grant clears the request.
- R10: One cycle after `done_i` or `ovr_i` during a grant, `stall_vld_o` is 1 for one cycle and `stall_o` equals the `used_i` value given with that pulse. Otherwise `stall_vld_o` is 0.
- R11: A write on `ctrl_wr_i` loads `ctrl_wdata_i` into `ctrl_q_o` on the next cycle, including during a halt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 6 | Request lines of channels 0 to 5 |
| ctrl_wr_i | input | 1 | Write strobe for the priority/enable word |
| ctrl_wdata_i | input | 32 | Priority/enable write data; enable of channel i is bit 4*i+3 |
| clr_wr_i | input | 1 | Write strobe for the table-clear channel control |
| clr_start_i | input | 1 | Start bit written with `clr_wr_i` |
| done_i | input | 1 | Granted transfer finished |
| ovr_i | input | 1 | Granted transfer exceeded its cycle budget |
| used_i | input | 16 | Cycles used by the transfer, valid with done or overrun |
| grant_o | output | 7 | One-hot channel grant |
| halted_o | output | 1 | Global halt in progress |
| stall_vld_o | output | 1 | Stall count valid |
| stall_o | output | 16 | CPU stall cycles |
| ctrl_q_o | output | 32 | Current priority/enable word |

## Verification
The hardest state to reach is an overrun that follows a halt. The resumed scan has to start from channel 0 while requests were raised and enables were written during the halt. The bench forces an overrun on channel 2 and then raises channel 0 mid-halt. It also enables and starts the table-clear channel mid-halt. It checks that nothing is granted before the halt ends and that channel 0 wins first on resume. A second overrun on that first resumed grant must produce another complete halt before channels 0, 2 and 6 are finally served in order.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  localparam int unsigned N_CH_DEF = 7;

  // field i of the control word holds i+1 for present channels, 0 otherwise
  function automatic logic [31:0] ctrl_rst_val(input int unsigned n);
    logic [31:0] v;
    v = '0;
    for (int unsigned i = 0; i < 8; i++)
      if (i < n) v[4*i +: 4] = 4'(i + 1);
    return v;
  endfunction
endpackage

// File: rtl/dma_halt_timer.sv
module dma_halt_timer #(
  parameter int unsigned HALT_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic halted_o
);
  localparam int unsigned CNT_W = $clog2(2*HALT_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= cnt_q + CNT_W'(HALT_CYC);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign halted_o = (cnt_q != '0);
endmodule

// File: rtl/dma_pick.sv
module dma_pick #(
  parameter int unsigned N  = 7,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  vld_i,
  input  logic [IW-1:0] from_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  // lowest valid index at or above from_i
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld_i[i] && (IW'(i) >= from_i)) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_sched.sv
module dma_sched
  import dma_sched_pkg::*;
#(
  parameter int unsigned N_CH     = N_CH_DEF,
  parameter int unsigned HALT_CYC = 100,
  parameter int unsigned CYC_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-2:0]  req_i,
  input  logic             ctrl_wr_i,
  input  logic [31:0]      ctrl_wdata_i,
  input  logic             clr_wr_i,
  input  logic             clr_start_i,
  input  logic             done_i,
  input  logic             ovr_i,
  input  logic [CYC_W-1:0] used_i,
  output logic [N_CH-1:0]  grant_o,
  output logic             halted_o,
  output logic             stall_vld_o,
  output logic [CYC_W-1:0] stall_o,
  output logic [31:0]      ctrl_q_o
);
  localparam int unsigned IW     = $clog2(N_CH + 1);
  localparam int unsigned CLR_CH = N_CH - 1;
  localparam logic [31:0] CTRL_RST = ctrl_rst_val(N_CH);

  logic [31:0]     ctrl_q;
  logic            clr_req_q;
  logic            busy_q;
  logic [N_CH-1:0] grant_q;
  logic [IW-1:0]   ptr_q;
  logic [N_CH-1:0] en, elig;
  logic            hit;
  logic [IW-1:0]   pick_idx;
  logic            halt_load;
  logic            xfer_end;

  for (genvar g = 0; g < N_CH; g++) begin : g_en
    assign en[g] = ctrl_q[4*g+3];
  end

  assign elig      = en & {clr_req_q, req_i};
  assign xfer_end  = busy_q & (done_i | ovr_i);
  assign halt_load = busy_q & ovr_i;

  dma_pick #(.N(N_CH), .IW(IW)) u_pick (
    .vld_i  (elig),
    .from_i (ptr_q),
    .hit_o  (hit),
    .idx_o  (pick_idx)
  );

  dma_halt_timer #(.HALT_CYC(HALT_CYC)) u_halt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (halt_load),
    .halted_o (halted_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else if (ctrl_wr_i) ctrl_q <= ctrl_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_req_q <= 1'b0;
    else if (clr_wr_i) clr_req_q <= clr_start_i;
    else if (busy_q && done_i && !ovr_i && grant_q[CLR_CH]) clr_req_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      grant_q     <= '0;
      ptr_q       <= '0;
      stall_vld_o <= 1'b0;
      stall_o     <= '0;
    end else begin
      stall_vld_o <= 1'b0;
      stall_o     <= '0;
      if (busy_q) begin
        if (xfer_end) begin
          busy_q      <= 1'b0;
          grant_q     <= '0;
          stall_vld_o <= 1'b1;
          stall_o     <= used_i;
          if (ovr_i) ptr_q <= '0;  // abandon the pass
        end
      end else if (!halted_o) begin
        if (hit) begin
          busy_q  <= 1'b1;
          grant_q <= N_CH'(1) << pick_idx;
          ptr_q   <= pick_idx + IW'(1);
        end else begin
          ptr_q <= '0;  // pass complete
        end
      end
    end
  end

  assign grant_o  = grant_q;
  assign ctrl_q_o = ctrl_q;
endmodule

// File: rtl/dma_sched_chk.sv
module dma_sched_chk #(
  parameter int unsigned N_CH     = 7,
  parameter int unsigned HALT_CYC = 100,
  parameter int unsigned CYC_W    = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_wr_i,
  input logic [31:0]      ctrl_wdata_i,
  input logic             done_i,
  input logic             ovr_i,
  input logic [CYC_W-1:0] used_i,
  input logic [N_CH-1:0]  grant_o,
  input logic             halted_o,
  input logic             stall_vld_o,
  input logic [CYC_W-1:0] stall_o,
  input logic [31:0]      ctrl_q_o
);
  logic [N_CH-1:0] en;
  int unsigned     hrun;

  always_comb
    for (int i = 0; i < N_CH; i++) en[i] = ctrl_q_o[4*i+3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hrun <= 0;
    else if (halted_o)  hrun <= hrun + 1;
    else                hrun <= 0;
  end

  p_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0 && !done_i && !ovr_i) |=> $stable(grant_o));

  p_enabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0 && $past(grant_o) == '0) |-> (($past(en) & grant_o) != '0));

  p_ovr_halts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0 && ovr_i) |=> (halted_o && grant_o == '0));

  p_halt_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (hrun < HALT_CYC));

  p_no_grant_halted_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (grant_o == '0));

  p_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0 && (done_i || ovr_i)) |=> (stall_vld_o && stall_o == $past(used_i)));

  p_ctrl_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> (ctrl_q_o == $past(ctrl_wdata_i)));
endmodule

bind dma_sched dma_sched_chk #(.N_CH(N_CH), .HALT_CYC(HALT_CYC), .CYC_W(CYC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_wr_i    (ctrl_wr_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .done_i       (done_i),
  .ovr_i        (ovr_i),
  .used_i       (used_i),
  .grant_o      (grant_o),
  .halted_o     (halted_o),
  .stall_vld_o  (stall_vld_o),
  .stall_o      (stall_o),
  .ctrl_q_o     (ctrl_q_o)
);

// File: tb/dma_sched_tb.sv
module dma_sched_tb;
  localparam logic [31:0] RST_WORD = 32'h0765_4321;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  req_i = '0;
  logic        ctrl_wr_i = 1'b0;
  logic [31:0] ctrl_wdata_i = '0;
  logic        clr_wr_i = 1'b0;
  logic        clr_start_i = 1'b0;
  logic        done_i = 1'b0;
  logic        ovr_i = 1'b0;
  logic [15:0] used_i = '0;
  logic [6:0]  grant_o;
  logic        halted_o;
  logic        stall_vld_o;
  logic [15:0] stall_o;
  logic [31:0] ctrl_q_o;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #5 clk_i = ~clk_i;

  dma_sched u_dut (.*);

  // {enable mask, request mask, expected grant}
  localparam logic [20:0] VEC [5] = '{
    {7'h7F, 7'h0A, 7'h02},
    {7'h08, 7'h0A, 7'h08},
    {7'h30, 7'h3F, 7'h10},
    {7'h01, 7'h01, 7'h01},
    {7'h20, 7'h1F, 7'h00}
  };

  function automatic logic [31:0] en_word(input logic [6:0] m);
    logic [31:0] w;
    w = RST_WORD;
    for (int i = 0; i < 7; i++) w[4*i+3] = m[i];
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic wr_ctrl(input logic [31:0] d);
    ctrl_wr_i = 1'b1; ctrl_wdata_i = d;
    tick();
    ctrl_wr_i = 1'b0;
  endtask

  task automatic wait_grant(output logic [6:0] g);
    g = '0;
    for (int k = 0; k < 6; k++) begin
      tick();
      if (grant_o != '0) begin g = grant_o; break; end
    end
  endtask

  task automatic finish_xfer(input bit ov, input logic [15:0] u);
    done_i = ~ov; ovr_i = ov; used_i = u;
    tick();
    done_i = 1'b0; ovr_i = 1'b0; used_i = '0;
    check(stall_vld_o && stall_o == u, "R10 stall report", {15'd0, stall_vld_o, stall_o}, {16'd1, u});
    check(grant_o == '0, "R3 grant dropped", grant_o, 0);
  endtask

  task automatic count_halt(input string tag);
    int n;
    n = 0;
    while (halted_o && n < 300) begin
      n++;
      if (grant_o != '0) check(0, "R6 grant during halt", grant_o, 0);
      tick();
    end
    check(n == 100, tag, n, 100);
  endtask

  initial begin
    logic [6:0] g;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    check(ctrl_q_o == RST_WORD, "R1 ctrl reset", ctrl_q_o, RST_WORD);
    check(grant_o == '0 && !halted_o && !stall_vld_o, "R1 outputs reset",
          {grant_o, halted_o, stall_vld_o}, 0);

    // table walk: lowest eligible channel
    for (int v = 0; v < 5; v++) begin
      req_i = VEC[v][12:7];
      wr_ctrl(en_word(VEC[v][20:14]));
      check(ctrl_q_o == en_word(VEC[v][20:14]), "R11 ctrl write", ctrl_q_o, en_word(VEC[v][20:14]));
      wait_grant(g);
      check(g == VEC[v][6:0], "R2 eligible pick", g, VEC[v][6:0]);
      if (g != '0) finish_xfer(0, 16'(v + 5));
      req_i = '0;
      wr_ctrl(RST_WORD);
      repeat (3) tick();
    end

    // ascending pass and wrap: channels 0,1,3,5 requesting
    req_i = 6'h2B;
    wr_ctrl(en_word(7'h7F));
    begin
      logic [6:0] seq [5] = '{7'h01, 7'h02, 7'h08, 7'h20, 7'h01};
      for (int s = 0; s < 5; s++) begin
        wait_grant(g);
        check(g == seq[s], "R4 ascending order", g, seq[s]);
        if (s == 0) begin
          repeat (3) tick();
          check(grant_o == seq[0], "R3 grant held", grant_o, seq[0]);
        end
        finish_xfer(0, 16'(20 + s));
        if (s == 4) req_i = '0;
      end
    end
    wr_ctrl(RST_WORD);
    repeat (3) tick();

    // overrun, halt, resume
    req_i = 6'h04;
    wr_ctrl(en_word(7'h05));
    wait_grant(g);
    check(g == 7'h04, "R2 grant ch2", g, 7'h04);
    finish_xfer(1, 16'd1000);
    check(halted_o == 1'b1, "R5 halt starts", halted_o, 1);
    begin
      int n;
      n = 0;
      while (halted_o && n < 300) begin
        n++;
        if (grant_o != '0) check(0, "R6 grant during halt", grant_o, 0);
        if (n == 10) req_i = 6'h05;
        if (n == 20) begin
          ctrl_wr_i = 1'b1; ctrl_wdata_i = en_word(7'h45);
          clr_wr_i = 1'b1; clr_start_i = 1'b1;
        end
        if (n == 21) begin
          ctrl_wr_i = 1'b0; clr_wr_i = 1'b0; clr_start_i = 1'b0;
          check(ctrl_q_o == en_word(7'h45), "R11 write during halt", ctrl_q_o, en_word(7'h45));
        end
        tick();
      end
      check(n == 100, "R5 halt length", n, 100);
    end
    wait_grant(g);
    check(g == 7'h01, "R7 resume from ch0", g, 7'h01);
    finish_xfer(1, 16'd999);
    check(halted_o == 1'b1, "R8 re-halt", halted_o, 1);
    count_halt("R8 second halt length");
    begin
      logic [6:0] seq2 [3] = '{7'h01, 7'h04, 7'h40};
      for (int s = 0; s < 3; s++) begin
        wait_grant(g);
        check(g == seq2[s], "R7 resumed pass order", g, seq2[s]);
        finish_xfer(0, 16'(40 + s));
        if (s == 2) req_i = '0;
      end
    end
    begin
      bit quiet;
      quiet = 1;
      for (int k = 0; k < 6; k++) begin tick(); if (grant_o != '0) quiet = 0; end
      check(quiet, "R9 done clears table-clear request", grant_o, 0);
    end

    // start=0 withdraws a pending table-clear request
    wr_ctrl(RST_WORD);
    clr_wr_i = 1'b1; clr_start_i = 1'b1; tick();
    clr_start_i = 1'b0; tick();
    clr_wr_i = 1'b0;
    wr_ctrl(en_word(7'h40));
    begin
      bit quiet;
      quiet = 1;
      for (int k = 0; k < 6; k++) begin tick(); if (grant_o != '0) quiet = 0; end
      check(quiet, "R9 start=0 withdraws", grant_o, 0);
    end
    clr_wr_i = 1'b1; clr_start_i = 1'b1; tick();
    clr_wr_i = 1'b0; clr_start_i = 1'b0;
    wait_grant(g);
    check(g == 7'h40, "R9 start=1 requests ch6", g, 7'h40);
    finish_xfer(0, 16'd3);

    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule